// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a load/store RISC core in which every arithmetic operation reads two registers and writes one. The program addresses 32 architectural registers with 5-bit numbers. Eight of them are globals shared by all procedures. The other 24 form a window that slides over a larger windowed array. The window has three groups of eight: incoming arguments, private locals, and outgoing arguments for the next callee.

A call command (save) moves the window down by sixteen physical registers. The caller's outgoing group then becomes the callee's incoming group, with no data copied. A return command (restore) moves the window back up. A window mask marks windows that are not available. A save or restore that would land on a marked window raises an overflow or underflow flag in the same cycle and leaves the pointer where it was. Software in the rest of the core decides how to spill or fill windows and reloads the mask.

The window count `NWIN` must be a power of two of at least 2. The default is 8 windows of 16 registers, which gives 128 windowed entries plus 8 globals.

Top module: `win_regfile`

## Requirements
- R1: Architectural numbers 0–7 select the globals, which are the same in every window. Global 0 always reads as zero, and writes to it are discarded.
- R2: The two read ports are combinational and independent. The single write port takes effect at the clock edge. A read of the register being written in the same cycle returns the old value.
- R3: Numbers 8–15 (outgoing group) and 16–23 (locals) select sixteen registers that belong only to the window at the current pointer.
- R4: Numbers 24–31 (incoming group) of window w are the same physical registers as numbers 8–15 of window (w+1) mod NWIN, and they can be written from either side.
- R5: A save moves the pointer to (w−1) mod NWIN. A restore moves it to (w+1) mod NWIN. The pointer is visible on `cwp`.
- R6: A save while mask bit (w−1) mod NWIN is set raises `overflow` in the same cycle, and the pointer does not move.
- R7: A restore while mask bit (w+1) mod NWIN is set raises `underflow` in the same cycle, and the pointer does not move. The flags are never raised without the matching command.
- R8: When save and restore arrive together, the save is acted on and the restore is ignored.
- R9: A write issued in the same cycle as a save or restore is mapped through the pointer value from before the move.
- R10: `mask_we` replaces the mask with `mask_din` at the clock edge. Flags raised in that same cycle use the old mask.
- R11: Reset sets the pointer to 0, sets only mask bit 1, clears all globals, and leaves both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Architectural number for read port A |
| rd_a_data | output | DATA_W | Read port A data (combinational) |
| rd_b_idx | input | 5 | Architectural number for read port B |
| rd_b_data | output | DATA_W | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural number for the write |
| wr_data | input | DATA_W | Write data |
| save_req | input | 1 | Call command: move window down |
| restore_req | input | 1 | Return command: move window up |
| mask_we | input | 1 | Load the window mask |
| mask_din | input | NWIN | New window mask |
| cwp | output | log2(NWIN) | Current window pointer |
| win_mask | output | NWIN | Current window mask |
| overflow | output | 1 | Save refused: target window marked |
| underflow | output | 1 | Restore refused: target window marked |

## Verification
The bench writes a value derived from the window number and register position into every outgoing and local register of all eight windows. It then walks back through each window and reads all 24 windowed numbers on both ports. A wrong group offset, a missed wrap or a wrong aliasing direction each shows up as a mismatch against the computed value. A write through an incoming register and a write combined with a save or a restore show whether aliasing works in both directions and which pointer value the write uses. Masks with a single bit set just below, just above and at no neighbour of the pointer separate overflow from underflow and show the save-over-restore priority. A mask load issued together with a save shows that the flag uses the old mask.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int ARCH_W  = 5;
  localparam int GRP_REGS = 8;

  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_INP = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int CWP_W  = $clog2(NWIN),
  parameter int PIDX_W = $clog2(NWIN * 16)
) (
  input  logic [ARCH_W-1:0] arch_idx,
  input  logic [CWP_W-1:0]  cwp,
  output logic              is_glb,
  output logic [2:0]        glb_idx,
  output logic [PIDX_W-1:0] win_idx
);
  reg_grp_e         grp;
  logic [CWP_W-1:0] wsel;
  logic [3:0]       woff;

  always_comb begin
    grp     = reg_grp_e'(arch_idx[4:3]);
    glb_idx = arch_idx[2:0];
    is_glb  = (grp == GRP_GLB);
    wsel    = cwp;
    woff    = {1'b0, arch_idx[2:0]};
    case (grp)
      GRP_LOC: woff = {1'b1, arch_idx[2:0]};
      GRP_INP: wsel = cwp + CWP_W'(1);
      default: ;
    endcase
    win_idx = {wsel, woff};
  end
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int NWIN  = 8,
  parameter int CWP_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic             mask_we,
  input  logic [NWIN-1:0]  mask_din,
  output logic [CWP_W-1:0] cwp,
  output logic [NWIN-1:0]  win_mask,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [NWIN-1:0] MASK_RST = NWIN'(2);

  logic [CWP_W-1:0] cwp_q, cwp_nxt, cwp_dn, cwp_inc;
  logic [NWIN-1:0]  mask_q;
  logic             cwp_en, rest_do;

  // next-state
  always_comb begin
    cwp_dn    = cwp_q - CWP_W'(1);
    cwp_inc   = cwp_q + CWP_W'(1);
    rest_do   = restore_req & ~save_req;
    overflow  = save_req & mask_q[cwp_dn];
    underflow = rest_do & mask_q[cwp_inc];
    cwp_en    = (save_req & ~overflow) | (rest_do & ~underflow);
    cwp_nxt   = save_req ? cwp_dn : cwp_inc;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q  <= '0;
      mask_q <= MASK_RST;
    end else begin
      if (cwp_en)  cwp_q  <= cwp_nxt;
      if (mask_we) mask_q <= mask_din;
    end
  end

  assign cwp      = cwp_q;
  assign win_mask = mask_q;
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int DATA_W = 32,
  parameter int NWIN   = 8,
  parameter int NRD    = 2,
  parameter int PIDX_W = $clog2(NWIN * 16)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic                        wr_is_glb,
  input  logic [2:0]                  wr_gidx,
  input  logic [PIDX_W-1:0]           wr_widx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NRD-1:0]              rd_is_glb,
  input  logic [NRD-1:0][2:0]         rd_gidx,
  input  logic [NRD-1:0][PIDX_W-1:0]  rd_widx,
  output logic [NRD-1:0][DATA_W-1:0]  rd_data
);
  localparam int NGLB    = 8;
  localparam int WIN_TOT = NWIN * 16;

  logic [DATA_W-1:0] glb_q   [NGLB];
  logic [DATA_W-1:0] win_mem [WIN_TOT];
  logic [NGLB-1:0]   glb_en;
  logic              win_we;

  always_comb begin
    win_we = we & ~wr_is_glb;
    for (int g = 0; g < NGLB; g++) begin
      glb_en[g] = we & wr_is_glb & (wr_gidx == 3'(g)) & (g != 0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGLB; g++) glb_q[g] <= '0;
    end else begin
      for (int g = 0; g < NGLB; g++) begin
        if (glb_en[g]) glb_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (win_we) win_mem[wr_widx] <= wr_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = rd_is_glb[p] ? glb_q[rd_gidx[p]] : win_mem[rd_widx[p]];
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWIN   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4:0]               rd_a_idx,
  output logic [DATA_W-1:0]        rd_a_data,
  input  logic [4:0]               rd_b_idx,
  output logic [DATA_W-1:0]        rd_b_data,
  input  logic                     wr_en,
  input  logic [4:0]               wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     save_req,
  input  logic                     restore_req,
  input  logic                     mask_we,
  input  logic [NWIN-1:0]          mask_din,
  output logic [$clog2(NWIN)-1:0]  cwp,
  output logic [NWIN-1:0]          win_mask,
  output logic                     overflow,
  output logic                     underflow
);
  localparam int CWP_W  = $clog2(NWIN);
  localparam int PIDX_W = $clog2(NWIN * 16);
  localparam int NPORT  = 3;   // read A, read B, write

  logic [NPORT-1:0][ARCH_W-1:0] map_idx;
  logic [NPORT-1:0]             map_glb;
  logic [NPORT-1:0][2:0]        map_gidx;
  logic [NPORT-1:0][PIDX_W-1:0] map_widx;
  logic [1:0][DATA_W-1:0]       rd_bus;

  assign map_idx = {wr_idx, rd_b_idx, rd_a_idx};

  wrf_window_ctl #(.NWIN(NWIN), .CWP_W(CWP_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .mask_we     (mask_we),
    .mask_din    (mask_din),
    .cwp         (cwp),
    .win_mask    (win_mask),
    .overflow    (overflow),
    .underflow   (underflow)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    wrf_addr_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PIDX_W(PIDX_W)) u_map (
      .arch_idx (map_idx[p]),
      .cwp      (cwp),
      .is_glb   (map_glb[p]),
      .glb_idx  (map_gidx[p]),
      .win_idx  (map_widx[p])
    );
  end

  wrf_storage #(.DATA_W(DATA_W), .NWIN(NWIN), .NRD(2), .PIDX_W(PIDX_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_en),
    .wr_is_glb (map_glb[2]),
    .wr_gidx   (map_gidx[2]),
    .wr_widx   (map_widx[2]),
    .wr_data   (wr_data),
    .rd_is_glb (map_glb[1:0]),
    .rd_gidx   (map_gidx[1:0]),
    .rd_widx   (map_widx[1:0]),
    .rd_data   (rd_bus)
  );

  assign rd_a_data = rd_bus[0];
  assign rd_b_data = rd_bus[1];
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int NWIN   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [4:0]              rd_a_idx,
  input logic [DATA_W-1:0]       rd_a_data,
  input logic                    save_req,
  input logic                    restore_req,
  input logic                    mask_we,
  input logic [NWIN-1:0]         mask_din,
  input logic [$clog2(NWIN)-1:0] cwp,
  input logic [NWIN-1:0]         win_mask,
  input logic                    overflow,
  input logic                    underflow
);
  // R1
  g0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

  // R5
  save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !overflow) |=> (cwp == $past(cwp) - 1'b1));

  // R5
  restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !underflow) |=> (cwp == $past(cwp) + 1'b1));

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> $stable(cwp));

  // R7
  udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> $stable(cwp));

  // R7
  udf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (restore_req && !save_req));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow));

  // R10
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (win_mask == $past(mask_din)));
endmodule

bind win_regfile win_regfile_chk #(.DATA_W(DATA_W), .NWIN(NWIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .save_req    (save_req),
  .restore_req (restore_req),
  .mask_we     (mask_we),
  .mask_din    (mask_din),
  .cwp         (cwp),
  .win_mask    (win_mask),
  .overflow    (overflow),
  .underflow   (underflow)
);

// File: tb/tb_win_regfile.sv
`timescale 1ns/1ps
module tb_win_regfile;
  localparam int DW = 32;
  localparam int NW = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4:0]    rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic          wr_en, save_req, restore_req, mask_we;
  logic [NW-1:0] mask_din, win_mask;
  logic [CW-1:0] cwp;
  logic          overflow, underflow;

  int n_chk  = 0;
  int n_fail = 0;
  int e_cwp  = 0;

  always #2 clk = ~clk;  // 250 MHz

  win_regfile #(.DATA_W(DW), .NWIN(NW)) dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .mask_we(mask_we), .mask_din(mask_din),
    .cwp(cwp), .win_mask(win_mask),
    .overflow(overflow), .underflow(underflow)
  );

  function automatic logic [31:0] pat(int w, int k);
    return 32'hC0DE_0000 | 32'(w << 8) | 32'(k);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0; mask_we = 1'b0;
  endtask

  task automatic peek(logic [4:0] a, logic [4:0] b);
    @(negedge clk);
    rd_a_idx = a; rd_b_idx = b;
    #1;
  endtask

  task automatic wr(logic [4:0] idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    tick();
  endtask

  task automatic load_mask(logic [NW-1:0] m);
    @(negedge clk);
    mask_we = 1'b1; mask_din = m;
    tick();
  endtask

  task automatic save_op();
    @(negedge clk);
    save_req = 1'b1;
    tick();
    e_cwp = (e_cwp + NW - 1) % NW;
  endtask

  task automatic restore_op();
    @(negedge clk);
    restore_req = 1'b1;
    tick();
    e_cwp = (e_cwp + 1) % NW;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0;
    mask_we = 1'b0; mask_din = '0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    #1;
    chk("R11 cwp", 32'(cwp), 0);
    chk("R11 mask", 32'(win_mask), 32'h2);
    chk("R11 ovf", 32'(overflow), 0);
    chk("R11 udf", 32'(underflow), 0);
    for (int k = 0; k < 8; k++) begin
      peek(5'(k), 5'(7 - k));
      chk("R11 glb A", rd_a_data, 0);
      chk("R11 glb B", rd_b_data, 0);
    end
    @(negedge clk);
    restore_req = 1'b1; #1;
    chk("R11/R7 udf reset mask", 32'(underflow), 1);
    tick();
    chk("R7 cwp held", 32'(cwp), 0);

    load_mask('0);

    // R1 globals
    for (int k = 0; k < 8; k++) wr(5'(k), 32'h1111_0000 + 32'(k) + 32'hFFFF_0000 * 32'(k == 0));
    for (int k = 0; k < 8; k++) begin
      peek(5'(k), 5'(7 - k));
      chk("R1/R2 glb A", rd_a_data, (k == 0) ? 32'h0 : 32'h1111_0000 + 32'(k));
      chk("R1/R2 glb B", rd_b_data, (k == 7) ? 32'h0 : 32'h1111_0000 + 32'(7 - k));
    end

    // R3/R5 fill every window, moving down
    for (int i = 0; i < NW; i++) begin
      for (int k = 0; k < 8; k++) begin
        wr(5'(8 + k), pat(e_cwp, k));
        wr(5'(16 + k), pat(e_cwp, 8 + k));
      end
      save_op();
      chk("R5 save step", 32'(cwp), 32'(e_cwp));
    end
    // R3/R4 walk back up and read everything
    for (int i = 0; i < NW; i++) begin
      chk("R5 cwp", 32'(cwp), 32'(e_cwp));
      for (int k = 0; k < 8; k++) begin
        peek(5'(8 + k), 5'(16 + k));
        chk("R3 out", rd_a_data, pat(e_cwp, k));
        chk("R3 loc", rd_b_data, pat(e_cwp, 8 + k));
        peek(5'(24 + k), 5'd3);
        chk("R4 in", rd_a_data, pat((e_cwp + 1) % NW, k));
        chk("R1 glb shared", rd_b_data, 32'h1111_0003);
      end
      restore_op();
    end

    // R4 write through input, see as caller output
    wr(5'd26, 32'hA11A_5001);
    restore_op();
    peek(5'd10, 5'd0);
    chk("R4 alias", rd_a_data, 32'hA11A_5001);
    chk("R1 g0", rd_b_data, 0);
    save_op();

    // R2 same-cycle read/write
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd17; wr_data = 32'hBEEF_0017; rd_a_idx = 5'd17;
    #1;
    chk("R2 old value", rd_a_data, pat(e_cwp, 9));
    tick();
    peek(5'd17, 5'd17);
    chk("R2 new value", rd_a_data, 32'hBEEF_0017);

    // R9 write with save uses old pointer
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'h5AFE_0009; save_req = 1'b1;
    tick();
    e_cwp = (e_cwp + NW - 1) % NW;
    peek(5'd25, 5'd0);
    chk("R9 save+write", rd_a_data, 32'h5AFE_0009);
    // R9 write with restore uses old pointer
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd16; wr_data = 32'h7E57_0016; restore_req = 1'b1;
    tick();
    e_cwp = (e_cwp + 1) % NW;
    save_op();
    peek(5'd16, 5'd0);
    chk("R9 restore+write", rd_a_data, 32'h7E57_0016);

    // R6 overflow
    load_mask(NW'(1) << ((e_cwp + NW - 1) % NW));
    chk("R10 mask", 32'(win_mask), 32'(1) << ((e_cwp + NW - 1) % NW));
    @(negedge clk);
    save_req = 1'b1; #1;
    chk("R6 ovf", 32'(overflow), 1);
    chk("R6 no udf", 32'(underflow), 0);
    tick();
    chk("R6 cwp held", 32'(cwp), 32'(e_cwp));
    @(negedge clk);
    restore_req = 1'b1; #1;
    chk("R7 no udf", 32'(underflow), 0);
    tick();
    e_cwp = (e_cwp + 1) % NW;
    chk("R5 restore step", 32'(cwp), 32'(e_cwp));

    // R7 underflow
    load_mask(NW'(1) << ((e_cwp + 1) % NW));
    @(negedge clk);
    restore_req = 1'b1; #1;
    chk("R7 udf", 32'(underflow), 1);
    chk("R7 no ovf", 32'(overflow), 0);
    tick();
    chk("R7 cwp held", 32'(cwp), 32'(e_cwp));

    // R8 save wins
    load_mask('0);
    @(negedge clk);
    save_req = 1'b1; restore_req = 1'b1; #1;
    chk("R8 ovf", 32'(overflow), 0);
    chk("R8 udf", 32'(underflow), 0);
    tick();
    e_cwp = (e_cwp + NW - 1) % NW;
    chk("R8 save wins", 32'(cwp), 32'(e_cwp));
    load_mask(NW'(1) << ((e_cwp + NW - 1) % NW));
    @(negedge clk);
    save_req = 1'b1; restore_req = 1'b1; #1;
    chk("R8 ovf both", 32'(overflow), 1);
    chk("R8 udf both", 32'(underflow), 0);
    tick();
    chk("R8 restore ignored", 32'(cwp), 32'(e_cwp));

    // R10 flags use old mask in load cycle
    @(negedge clk);
    mask_we = 1'b1; mask_din = '0; save_req = 1'b1; #1;
    chk("R10 old mask ovf", 32'(overflow), 1);
    tick();
    chk("R10 cwp held", 32'(cwp), 32'(e_cwp));
    chk("R10 mask loaded", 32'(win_mask), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule